// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Per-Pin Edge Interrupts

This block is one 8-bit general-purpose I/O port on a simple byte-wide register bus. Every pin is configured on its own. Software chooses whether the pin drives or listens, what it drives, and whether a pull resistor is requested and in which direction. It can also hand the pin to an alternate function. Incoming levels pass through a synchroniser, are compared with their value one cycle earlier, and set a sticky per-pin flag on the edge that software selected. Software can read these flags, set them and clear them.

A single interrupt line is raised whenever an enabled flag is pending. Software accesses the port with plain byte reads and writes. Each bus transfer completes in one cycle: writes are captured on the clock edge, and read data is combinational from the address.

Register offsets on `busAddr` are: 0 input level, 1 output value, 2 direction, 3 function select, 4 pull enable, 5 interrupt enable, 6 edge select, 7 flags.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every writable register reads 0x00, `pinOe`, `pullUpReq` and `pullDnReq` are 0x00, and `irq` is 0.
- R2: A direction bit of 1 at offset 2 makes the pin an output. While its select bit is 0, `pinOe` follows the direction bit and `pinOut` follows the output bit.
- R3: The output register at offset 1 is read/write, and a read returns the last byte written. Each writable register at offsets 1 to 6 reads back the byte last written to it.
- R4: Offset 0 is read-only. It returns the pin levels after a two-flop synchroniser, so a pin change is readable after two clock edges and not after one. A write to offset 0 has no effect.
- R5: For each pin whose pull-enable bit (offset 4) is 1, the output bit chooses the pull direction: 1 requests pull-up (`pullUpReq`) and 0 requests pull-down (`pullDnReq`). A pin with pull-enable 0 requests neither.
- R6: An edge-select bit of 0 (offset 6) sets the pin's flag on a low-to-high transition, and a bit of 1 sets it on a high-to-low transition. The opposite transition sets nothing. Changing the edge select while the pin level is steady sets nothing. The flag becomes visible three clock edges after the pin changes.
- R7: Flags at offset 7 are sticky. Hardware never clears them. A software write loads the written byte, so writing 1 sets a flag and writing 0 clears it.
- R8: When hardware detects an edge on a pin in the same cycle that software writes 0 to that pin's flag, the flag ends up set.
- R9: `irq` is 1 exactly when some pin has both its interrupt-enable bit (offset 5) and its flag set.
- R10: A function-select bit of 1 (offset 3) makes that pin's `pinOut` and `pinOe` come from `altOut` and `altOe` instead of the output and direction registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus transfer valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational, zero when not reading |
| pinIn | input | 8 | Asynchronous pin levels |
| altOut | input | 8 | Alternate-function output values |
| altOe | input | 8 | Alternate-function output enables |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| pullUpReq | output | 8 | Pull-up requested per pin |
| pullDnReq | output | 8 | Pull-down requested per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The following properties are checked on every cycle:
- the register decode raises at most one write strobe;
- output and direction writes land in the next cycle;
- flags never drop without a flag write;
- a detected edge always leaves its flag set, even against a clearing write;
- `irq` never rises without a pending flag.

Some behaviours can only be shown by the bench's scenarios:
- the synchroniser latency;
- the choice between rising and falling edge;
- the absence of flags when only the edge select changes;
- the pull direction;
- the switch to alternate-function outputs;
- the exact cycle in which a same-cycle write and edge collide.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN    = 3'd0,
    REG_OUT   = 3'd1,
    REG_DIR   = 3'd2,
    REG_SEL   = 3'd3,
    REG_PULL  = 3'd4,
    REG_IRQEN = 3'd5,
    REG_EDGE  = 3'd6,
    REG_FLAG  = 3'd7
  } regAddr_t;

  typedef struct packed {
    logic             wrOut;
    logic             wrDir;
    logic             wrSel;
    logic             wrPull;
    logic             wrIrqEn;
    logic             wrEdge;
    logic             wrFlag;
    logic             rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } portStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobe_t       strobe
);
  logic isWrite;
  assign isWrite = busSel && busWrite;

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = busSel && !busWrite;
    strobe.rdAddr = busAddr;
    if (isWrite) begin
      case (regAddr_t'(busAddr))
        REG_OUT:   strobe.wrOut   = 1'b1;
        REG_DIR:   strobe.wrDir   = 1'b1;
        REG_SEL:   strobe.wrSel   = 1'b1;
        REG_PULL:  strobe.wrPull  = 1'b1;
        REG_IRQEN: strobe.wrIrqEn = 1'b1;
        REG_EDGE:  strobe.wrEdge  = 1'b1;
        REG_FLAG:  strobe.wrFlag  = 1'b1;
        default:   ;
      endcase
    end
  end

  // R3: a single transfer updates at most one register
  assert_one_write_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOut, strobe.wrDir, strobe.wrSel, strobe.wrPull,
              strobe.wrIrqEn, strobe.wrEdge, strobe.wrFlag}));
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [PORT_W-1:0] busWdata,
  input  logic [PORT_W-1:0] pinIn,
  input  logic [PORT_W-1:0] altOut,
  input  logic [PORT_W-1:0] altOe,
  output logic [PORT_W-1:0] busRdata,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pullUpReq,
  output logic [PORT_W-1:0] pullDnReq,
  output logic              irq
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [PORT_W-1:0] outReg, dirReg, selReg, pullReg, irqEnReg, edgeReg, flagReg;
  logic [SYNC_STAGES-1:0][PORT_W-1:0] syncChain;
  logic [PORT_W-1:0] pinLevel, prevLevel, edgeHit, flagNext;

  assign pinLevel = syncChain[LAST_STAGE];

  always_comb begin
    flagNext = (strobe.wrFlag ? busWdata : flagReg) | edgeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg    <= '0;
      dirReg    <= '0;
      selReg    <= '0;
      pullReg   <= '0;
      irqEnReg  <= '0;
      edgeReg   <= '0;
      flagReg   <= '0;
      syncChain <= '0;
      prevLevel <= '0;
    end else begin
      if (strobe.wrOut)   outReg   <= busWdata;
      if (strobe.wrDir)   dirReg   <= busWdata;
      if (strobe.wrSel)   selReg   <= busWdata;
      if (strobe.wrPull)  pullReg  <= busWdata;
      if (strobe.wrIrqEn) irqEnReg <= busWdata;
      if (strobe.wrEdge)  edgeReg  <= busWdata;
      flagReg   <= flagNext;
      syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
      prevLevel <= pinLevel;
    end
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    assign edgeHit[b]   = edgeReg[b] ? (prevLevel[b] & ~pinLevel[b])
                                     : (~prevLevel[b] & pinLevel[b]);
    assign pinOut[b]    = selReg[b] ? altOut[b] : outReg[b];
    assign pinOe[b]     = selReg[b] ? altOe[b]  : dirReg[b];
    assign pullUpReq[b] = pullReg[b] & outReg[b];
    assign pullDnReq[b] = pullReg[b] & ~outReg[b];
  end

  assign irq = |(irqEnReg & flagReg);

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      case (regAddr_t'(strobe.rdAddr))
        REG_IN:    busRdata = pinLevel;
        REG_OUT:   busRdata = outReg;
        REG_DIR:   busRdata = dirReg;
        REG_SEL:   busRdata = selReg;
        REG_PULL:  busRdata = pullReg;
        REG_IRQEN: busRdata = irqEnReg;
        REG_EDGE:  busRdata = edgeReg;
        REG_FLAG:  busRdata = flagReg;
        default:   busRdata = '0;
      endcase
    end
  end

  // R3: an output write lands on the next cycle
  assert_out_written_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrOut |=> (outReg == $past(busWdata)));

  // R2: a direction write lands on the next cycle
  assert_dir_written_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> (dirReg == $past(busWdata)));

  // R7: without a flag write no flag bit drops
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrFlag |=> ((flagReg & $past(flagReg)) == $past(flagReg)));

  // R8: a detected edge always leaves its flag set
  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((flagReg & $past(edgeHit)) == $past(edgeHit)));

  // R9: no request without a pending flag
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|flagReg));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] pinIn,
  input  logic [PORT_W-1:0] altOut,
  input  logic [PORT_W-1:0] altOe,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pullUpReq,
  output logic [PORT_W-1:0] pullDnReq,
  output logic              irq
);
  portStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_port_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .pinIn     (pinIn),
    .altOut    (altOut),
    .altOe     (altOe),
    .busRdata  (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pullUpReq (pullUpReq),
    .pullDnReq (pullDnReq),
    .irq       (irq)
  );
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWrite = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic [7:0] pinIn = 8'h00, altOut = 8'h06, altOe = 8'h0F;
  logic [7:0] pinOut, pinOe, pullUpReq, pullDnReq;
  logic       irq;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_edge_port dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .altOut(altOut), .altOe(altOe),
    .pinOut(pinOut), .pinOe(pinOe), .pullUpReq(pullUpReq),
    .pullDnReq(pullDnReq), .irq(irq)
  );

  // {requirement, address, write data, expected read-back}
  localparam int NVEC = 7;
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd3, 3'd1, 8'hA5, 8'hA5},
    {4'd2, 3'd2, 8'h3C, 8'h3C},
    {4'd10, 3'd3, 8'h0F, 8'h0F},
    {4'd5, 3'd4, 8'hF0, 8'hF0},
    {4'd9, 3'd5, 8'h0F, 8'h0F},
    {4'd6, 3'd6, 8'h55, 8'h55},
    {4'd4, 3'd0, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pull", pullUpReq | pullDnReq, 8'h00);
    rd(3'd7, v); check("R1 flags", v, 8'h00);
    rd(3'd2, v); check("R1 dir", v, 8'h00);

    // register table: write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check($sformatf("R%0d readback addr %0d", VEC[i][22:19], VEC[i][18:16]), v, VEC[i][7:0]);
    end

    // R10 alternate function on low nibble
    check("R10 pinOut", pinOut, 8'hA6);
    check("R10 pinOe", pinOe, 8'h3F);
    // R5 pull direction from output register
    check("R5 pullUp", pullUpReq, 8'hA0);
    check("R5 pullDn", pullDnReq, 8'h50);
    // R2 plain GPIO once select cleared
    wr(3'd3, 8'h00);
    check("R2 pinOe", pinOe, 8'h3C);
    check("R2 pinOut", pinOut, 8'hA5);

    // R4 synchroniser latency
    @(negedge clk) pinIn = 8'h81;
    @(posedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 3'd0;
    @(negedge clk); check("R4 one edge", busRdata, 8'h00);
    @(negedge clk); check("R4 two edges", busRdata, 8'h81);
    busSel = 1'b0;
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R4 write ignored", v, 8'h81);

    // R6: edge select 0x55 -> bit0 falling, bit7 rising
    rd(3'd7, v); check("R6 rising on bit7 only", v, 8'h80);
    check("R9 irq off, bit7 not enabled", {7'd0, irq}, 8'h00);
    @(negedge clk) pinIn = 8'h00;
    repeat (3) @(posedge clk);
    rd(3'd7, v); check("R6 falling on bit0, R7 bit7 sticky", v, 8'h81);
    check("R9 irq from bit0", {7'd0, irq}, 8'h01);

    // R7 software clear and set
    wr(3'd7, 8'h80);
    rd(3'd7, v); check("R7 clear bit0", v, 8'h80);
    check("R9 irq cleared", {7'd0, irq}, 8'h00);
    wr(3'd7, 8'h02);
    rd(3'd7, v); check("R7 software set", v, 8'h02);
    check("R9 irq from sw flag", {7'd0, irq}, 8'h01);

    // R8 edge on bit1 collides with a write of zero
    @(negedge clk) pinIn = 8'h02;
    @(posedge clk);
    @(posedge clk);
    wr(3'd7, 8'h00);
    rd(3'd7, v); check("R8 hw set wins", v, 8'h02);

    // R6 edge-select change on steady level sets nothing
    wr(3'd7, 8'h00);
    wr(3'd6, 8'hFF);
    repeat (4) @(posedge clk);
    rd(3'd7, v); check("R6 no flag on select change", v, 8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule